// File: doc/BRIEF.md
# Sticky Event Flag and Interrupt Mask Unit

This block collects single-cycle event pulses from a two-wire serial bus controller into sticky flag bits and turns them into one level-sensitive interrupt line. Each flag stays set until software clears it by writing a one to its position at the flag address. Writing a zero there leaves the flag alone. Each source also has a mask bit, where a set bit blocks that source from the interrupt. Software sets mask bits through a write-one "block" address and clears them through a write-one "allow" address. A read-only address shows the current mask.

The ten-bit source field uses these positions. The transfer group sits in the low bits: 0 transfer complete, 1 more data needed, 2 no acknowledge, 3 transfer timeout. The upper bits hold 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, and 9 arbitration lost. Bit 8 is not a source, so the set of valid positions is 0x2FF. Arbitration lost, the three FIFO faults, timeout and no acknowledge count as error sources. The interrupt is high while any flag is set and unmasked.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset every flag reads 0, the mask reads 0x2FF (all valid sources blocked) and irq_o is 0.
- R2: A 1 on a valid bit of evt_i during a clock edge sets that flag bit at the same edge. The flag stays set after the pulse ends, until software clears it.
- R3: A write to the flag address (word address 0) clears each flag bit whose write-data bit is 1 and leaves bits whose write-data bit is 0 unchanged.
- R4: If an event pulse and a clearing write reach the same flag bit on the same edge, the bit ends up set.
- R5: A write to the allow address (2) clears the mask bits at the positions written with 1. A write to the block address (3) sets the mask bits at the positions written with 1. Zero bits leave the mask unchanged.
- R6: irq_o is a registered output. It changes on the same edge as the flag and mask registers and equals the OR of (flags AND NOT mask).
- R7: Bit 8 is not a source. Its events are ignored, allow and block writes do not change it, and both its flag and its mask read 0. Read data bits 15..10 always read 0.
- R8: Reads return data combinationally. Address 0 returns the flags, address 1 returns the mask, and every other address, including 2 and 3, returns 0.
- R9: A write to the mask view address (1) has no effect on the mask or on the flags.
- R10: A flag is recorded whether its source is masked or not. Masking only blocks the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | Event pulses, one bit per source position |
| bus_addr_i | input | 4 | Register word address |
| bus_we_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| irq_o | output | 1 | Interrupt request, high while an unmasked flag is set |

## Verification
A flag register that lost or invented a bit would show up at the next read of address 0. The same error could show on irq_o one edge after the stimulus, but only if that source is unmasked. A wrong mask state shows at address 1, and on irq_o as soon as its source's flag is set. For that reason the sequence unmasks sources both before and after their flags are set. Collisions between an event and a clearing write are checked on the same edge. The unused bit 8 is checked for absence after every kind of write aimed at it.

// File: rtl/eic_pkg.sv
package eic_pkg;
    // Word offsets of the register bus.
    localparam int unsigned OFS_FLAGS = 0;
    localparam int unsigned OFS_MASK  = 1;
    localparam int unsigned OFS_ALLOW = 2;
    localparam int unsigned OFS_BLOCK = 3;

    // Default source count and valid positions (bit 8 unused).
    localparam int unsigned DEF_SRC_W = 10;
    localparam logic [DEF_SRC_W-1:0] DEF_VALID = 10'h2FF;

    typedef struct packed {
        logic clr;     // write-one-to-clear on flags
        logic allow;   // write-one clears mask bits
        logic block;   // write-one sets mask bits
    } wr_sel_t;

    typedef enum logic [1:0] {
        RD_NONE  = 2'd0,
        RD_FLAGS = 2'd1,
        RD_MASK  = 2'd2
    } rd_sel_e;
endpackage

// File: rtl/eic_decode.sv
module eic_decode
    import eic_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output wr_sel_t           wsel,
    output rd_sel_e           rsel
);
    always_comb begin
        wsel = '0;
        rsel = RD_NONE;
        if (addr == ADDR_W'(OFS_FLAGS)) begin
            rsel      = RD_FLAGS;
            wsel.clr  = we;
        end else if (addr == ADDR_W'(OFS_MASK)) begin
            rsel      = RD_MASK;
        end else if (addr == ADDR_W'(OFS_ALLOW)) begin
            wsel.allow = we;
        end else if (addr == ADDR_W'(OFS_BLOCK)) begin
            wsel.block = we;
        end
    end
endmodule

// File: rtl/eic_flags.sv
module eic_flags #(
    parameter int unsigned      SRC_W = 10,
    parameter logic [SRC_W-1:0] VALID = 10'h2FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] evt,
    input  logic             clr,
    input  logic [SRC_W-1:0] wd,
    output logic [SRC_W-1:0] flags_q,
    output logic [SRC_W-1:0] flags_d
);
    typedef struct packed {
        logic [SRC_W-1:0] flags;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        logic [SRC_W-1:0] kill;
        st_d = st_q;
        kill = clr ? wd : '0;
        // set wins over clear on the same edge
        st_d.flags = ((st_q.flags & ~kill) | evt) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign flags_d = st_d.flags;
endmodule

// File: rtl/eic_mask.sv
module eic_mask #(
    parameter int unsigned      SRC_W = 10,
    parameter logic [SRC_W-1:0] VALID = 10'h2FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             allow,
    input  logic             block,
    input  logic [SRC_W-1:0] wd,
    output logic [SRC_W-1:0] mask_q,
    output logic [SRC_W-1:0] mask_d
);
    typedef struct packed {
        logic [SRC_W-1:0] mask;
    } mk_state_t;

    mk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (allow) st_d.mask = st_d.mask & ~wd;
        if (block) st_d.mask = st_d.mask | wd;
        st_d.mask = st_d.mask & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.mask <= VALID;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;
    assign mask_d = st_d.mask;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import eic_pkg::*;
#(
    parameter int unsigned      SRC_W  = DEF_SRC_W,
    parameter int unsigned      DATA_W = 16,
    parameter int unsigned      ADDR_W = 4,
    parameter logic [SRC_W-1:0] VALID  = DEF_VALID
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  evt_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    wr_sel_t          wsel;
    rd_sel_e          rsel;
    logic [SRC_W-1:0] wd_src;
    logic [SRC_W-1:0] flags_q, flags_d;
    logic [SRC_W-1:0] mask_q, mask_d;

    assign wd_src = bus_wdata_i[SRC_W-1:0];

    generate
        if (DATA_W > SRC_W) begin : g_hi
            logic unused_wd_hi;
            assign unused_wd_hi = ^bus_wdata_i[DATA_W-1:SRC_W];
        end
    endgenerate

    eic_decode #(.ADDR_W(ADDR_W)) u_dec (
        .we   (bus_we_i),
        .addr (bus_addr_i),
        .wsel (wsel),
        .rsel (rsel)
    );

    eic_flags #(.SRC_W(SRC_W), .VALID(VALID)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .clr     (wsel.clr),
        .wd      (wd_src),
        .flags_q (flags_q),
        .flags_d (flags_d)
    );

    eic_mask #(.SRC_W(SRC_W), .VALID(VALID)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .allow  (wsel.allow),
        .block  (wsel.block),
        .wd     (wd_src),
        .mask_q (mask_q),
        .mask_d (mask_d)
    );

    // Read multiplexer
    always_comb begin
        unique case (rsel)
            RD_FLAGS: bus_rdata_o = DATA_W'(flags_q);
            RD_MASK:  bus_rdata_o = DATA_W'(mask_q);
            default:  bus_rdata_o = '0;
        endcase
    end

    // Interrupt register, follows the next flag/mask state
    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t ir_d, ir_q;

    always_comb begin
        ir_d     = ir_q;
        ir_d.irq = |(flags_d & ~mask_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign irq_o = ir_q.irq;
endmodule

// File: rtl/eic_checker.sv
module eic_checker
    import eic_pkg::*;
#(
    parameter int unsigned      SRC_W  = 10,
    parameter int unsigned      DATA_W = 16,
    parameter int unsigned      ADDR_W = 4,
    parameter logic [SRC_W-1:0] VALID  = 10'h2FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  evt,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [SRC_W-1:0]  flags,
    input logic [SRC_W-1:0]  mask
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == '0 && mask == VALID && !irq));

    a_r2_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & VALID)) |=> ((flags & $past(evt & VALID)) == $past(evt & VALID)));

    a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFS_FLAGS))
        |=> ((flags & $past(wdata[SRC_W-1:0] & ~evt)) == '0));

    a_r5_allow_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFS_ALLOW))
        |=> ((mask & $past(wdata[SRC_W-1:0])) == '0));

    a_r5_block_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFS_BLOCK))
        |=> ((mask & $past(wdata[SRC_W-1:0] & VALID)) == $past(wdata[SRC_W-1:0] & VALID)));

    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(flags & ~mask)));

    a_r7_unused_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~VALID) == '0) && ((mask & ~VALID) == '0)
        && ((rdata >> SRC_W) == '0));

    a_r9_mask_view_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFS_MASK)) |=> $stable(mask));
endmodule

bind evt_irq_ctrl eic_checker #(
    .SRC_W(SRC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VALID(VALID)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_i),
    .addr  (bus_addr_i),
    .we    (bus_we_i),
    .wdata (bus_wdata_i),
    .rdata (bus_rdata_o),
    .irq   (irq_o),
    .flags (flags_q),
    .mask  (mask_q)
);

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] VLD = 10'h2FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt = '0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model of flags and mask
    logic [9:0] m_fl = '0;
    logic [9:0] m_mk = VLD;

    typedef struct {
        logic [15:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // monitor: compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (rdata !== e.rd || irq !== e.irq) begin
                    bad++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, rdata, irq, e.rd, e.irq);
                end
            end
        end
    end

    // one edge of stimulus, then idle; model updated from the requirements
    task automatic op(input logic w, input logic [3:0] a,
                      input logic [15:0] d, input logic [9:0] ev);
        logic [9:0] dv;
        we = w; addr = a; wdata = d; evt = ev;
        @(posedge clk);
        #1;
        we = 1'b0; wdata = '0; evt = '0;
        dv = d[9:0];
        if (w && a == 4'd0) m_fl = m_fl & ~dv;
        m_fl = (m_fl | ev) & VLD;
        if (w && a == 4'd2) m_mk = m_mk & ~dv;
        if (w && a == 4'd3) m_mk = (m_mk | dv) & VLD;
    endtask

    task automatic chk(input logic [3:0] a, input string tag);
        exp_t e;
        we = 1'b0; evt = '0; addr = a;
        e.rd  = (a == 4'd0) ? {6'd0, m_fl} : (a == 4'd1) ? {6'd0, m_mk} : 16'h0;
        e.irq = |(m_fl & ~m_mk);
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(4'd0, "R1 flags clear after reset");
        chk(4'd1, "R1 mask all blocked after reset");

        op(1'b0, 4'd0, 16'h0, 10'h001);
        chk(4'd0, "R2 R10 masked event recorded, irq low");
        op(1'b0, 4'd0, 16'h0, 10'h000);
        op(1'b0, 4'd0, 16'h0, 10'h000);
        chk(4'd0, "R2 flag sticky after pulse");

        op(1'b1, 4'd2, 16'h0001, '0);
        chk(4'd1, "R5 R6 allow bit0 raises irq");

        op(1'b1, 4'd0, 16'h0000, '0);
        chk(4'd0, "R3 zero write keeps flags");
        op(1'b1, 4'd0, 16'h0001, '0);
        chk(4'd0, "R3 R6 one write clears, irq drops");

        op(1'b0, 4'd0, 16'h0, 10'h2FE);
        chk(4'd0, "R2 many sources set, still masked");

        op(1'b1, 4'd0, 16'h0200, 10'h200);
        chk(4'd0, "R4 event beats clear on same bit");
        op(1'b1, 4'd0, 16'h0004, 10'h001);
        chk(4'd0, "R3 R4 clear bit2 while bit0 arrives");

        op(1'b0, 4'd0, 16'h0, 10'h100);
        chk(4'd0, "R7 bit8 event ignored");
        op(1'b1, 4'd3, 16'h0100, '0);
        op(1'b1, 4'd2, 16'h0100, '0);
        chk(4'd1, "R7 bit8 mask unaffected");

        op(1'b1, 4'd1, 16'h0000, '0);
        chk(4'd1, "R9 mask view write ignored");
        chk(4'd0, "R9 flags unchanged by mask view write");

        chk(4'd2, "R8 allow address reads zero");
        chk(4'd3, "R8 block address reads zero");
        chk(4'd7, "R8 unmapped address reads zero");

        op(1'b1, 4'd3, 16'h0001, '0);
        chk(4'd1, "R5 block bit0 masks again");

        op(1'b1, 4'd2, 16'h0200, '0);
        chk(4'd0, "R6 R10 allow after flag raises irq");
        op(1'b1, 4'd3, 16'hFFFF, '0);
        chk(4'd1, "R5 R7 block all, upper bits dropped");
        chk(4'd0, "R6 irq low once all blocked");

        op(1'b1, 4'd2, 16'h0010, '0);
        op(1'b0, 4'd0, 16'h0, 10'h010);
        chk(4'd0, "R2 R6 unmasked event raises irq");
        op(1'b1, 4'd0, 16'hFFFF, '0);
        chk(4'd0, "R3 R7 clear all");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule